// File: doc/BRIEF.md
# SMBus Register Access Command Sequencer

This block sits behind a byte-level SMBus slave interface. It turns each accepted SMBus transaction into one 32-bit access on a simple internal register bus. The slave front end hands over every received byte, marking the first byte after the address match, and signals a stop condition. The sequencer answers each byte with an accept or reject decision. The first byte is a command byte. It tells the block whether the access is a read or a write, which address space it targets, and whether the transaction opens or closes a multi-transaction sequence. Address bytes and, for writes, data bytes follow, most significant byte first.

A write is issued once the stop arrives with all bytes present; an incomplete write is dropped. A read command carries only the address. Its internal read starts at the stop, and a later SMBus read transaction collects a status byte followed by the four data bytes. From the moment a command is accepted until the internal bus completes the access, the block rejects every new command and every read request, so a transfer in flight cannot be disturbed.

Top module: `smb_cmd_seq`

## Requirements
- R1: After reset, no internal access is pending (bus_valid low), rx_ack and tx_ack are low, and no sequence is open.
- R2: Command bit 7 opens a sequence and bit 6 closes it. A command with bit 7 clear is accepted only while a sequence is open. Accepting a command with bit 6 set closes the sequence.
- R3: A command with bit 4 (checksum enable) set is rejected, and no internal access results from that transaction.
- R4: Command bit 5 selects the target space. bus_cfg equals 1 for configuration registers and 0 for memory-mapped space.
- R5: After the command, bytes are taken as address [15:8], address [7:0], then data [31:24], [23:16], [15:8], [7:0]. They appear on bus_addr and bus_wdata.
- R6: A write (command bit 0 = 0) is issued only when the stop arrives after exactly six bytes have followed the command. A shorter transaction is discarded, and any byte beyond the sixth is rejected.
- R7: A read command (bit 0 = 1) takes two address bytes, rejects any further byte, and issues an internal read at the stop.
- R8: From command acceptance until bus_ready completes the internal access, any new command byte and any read transaction start are rejected.
- R9: A read transaction returns a status byte, then data [31:24] down to [7:0] of the last completed internal read, then 8'hFF. The status byte is 8'h01 when that data is valid, and 8'h00 after reset or once a new read command has been accepted. tx_data is 8'h00 whenever tx_ack is low.
- R10: Once bus_valid rises, it stays high with stable bus_write, bus_cfg, bus_addr and bus_wdata until the cycle in which bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte written by the host is present |
| rx_first | input | 1 | The present byte is the first of the transaction (command) |
| rx_data | input | 8 | Received byte |
| rx_stop | input | 1 | Stop condition ends the current transaction |
| rx_ack | output | 1 | Accept (1) or reject (0) for the present received byte |
| tx_req | input | 1 | The host is reading a byte |
| tx_first | input | 1 | The byte requested is the first of a read transaction |
| tx_ack | output | 1 | Read request accepted |
| tx_data | output | 8 | Byte returned to the host |
| bus_valid | output | 1 | Internal access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_cfg | output | 1 | 1 for configuration space, 0 for memory-mapped space |
| bus_addr | output | 16 | Register number pair or memory offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Internal access completes |
| bus_rdata | input | 32 | Read data, taken when bus_ready is high |

## Verification
The assertions take for granted that the front end never raises rx_stop in the same cycle as rx_valid or tx_req. They also assume rx_first and tx_first appear only together with their valid or request strobe, that received and read bytes never share a cycle, and that bus_ready is raised only while bus_valid is high. The bench drives each byte for a single cycle with an idle cycle between bytes and gives the stop a cycle of its own. Its bus responder raises bus_ready for one cycle, a fixed delay after it sees a request, so all of these conditions always hold.

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_first,
  input  logic [7:0]    rx_data,
  input  logic          rx_stop,
  output logic          rx_ack,
  input  logic          tx_req,
  input  logic          tx_first,
  output logic          tx_ack,
  output logic [7:0]    tx_data,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          bus_cfg,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);
  localparam int AB   = AW / 8;
  localparam int DB   = DW / 8;
  localparam int WR_N = 1 + AB + DB;
  localparam int RD_N = 1 + AB;
  localparam int CW   = $clog2(WR_N + 1);
  localparam int TW   = $clog2(DB + 2);

  logic          in_txn, seq_open, rd_on, avail;
  logic [7:0]    cmd_q;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [DW-1:0] rdata_q;
  logic [7:0]    dsel;

  wire           busy    = in_txn | bus_valid;
  wire           is_rd   = cmd_q[0];
  wire [CW-1:0]  need    = is_rd ? CW'(RD_N) : CW'(WR_N);
  wire           cmd_ok  = !busy && !rx_data[4] && (rx_data[7] || seq_open);
  wire           cmd_acc = rx_valid && rx_first && cmd_ok;

  assign rx_ack  = rx_valid && (rx_first ? cmd_ok : (in_txn && cnt < need));
  wire   rx_take = rx_ack && !rx_first;

  assign tx_ack  = tx_req && (tx_first ? !busy : rd_on);
  wire [TW-1:0] tidx = tx_first ? '0 : tcnt;

  always_comb begin
    if (tidx == '0)             dsel = {7'b0, avail};
    else if (int'(tidx) <= DB)  dsel = 8'(rdata_q >> (DW - 8 * int'(tidx)));
    else                        dsel = 8'hFF;
  end
  assign tx_data = tx_ack ? dsel : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_txn    <= 1'b0;
      seq_open  <= 1'b0;
      rd_on     <= 1'b0;
      avail     <= 1'b0;
      cmd_q     <= '0;
      cnt       <= '0;
      tcnt      <= '0;
      rdata_q   <= '0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_cfg   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      if (cmd_acc) begin
        in_txn   <= 1'b1;
        cmd_q    <= rx_data;
        cnt      <= CW'(1);
        seq_open <= !rx_data[6];
        if (rx_data[0]) avail <= 1'b0;
      end else if (rx_take) begin
        cnt <= cnt + CW'(1);
        if (cnt <= CW'(AB)) bus_addr  <= {bus_addr[AW-9:0], rx_data};
        else                bus_wdata <= {bus_wdata[DW-9:0], rx_data};
      end

      if (rx_stop && in_txn) begin
        in_txn <= 1'b0;
        if (cnt == need) begin
          bus_valid <= 1'b1;
          bus_write <= !is_rd;
          bus_cfg   <= cmd_q[5];
        end
      end

      if (bus_valid && bus_ready) begin
        bus_valid <= 1'b0;
        if (!bus_write) begin
          rdata_q <= bus_rdata;
          avail   <= 1'b1;
        end
      end

      if (tx_ack) begin
        rd_on <= 1'b1;
        tcnt  <= (tidx == TW'(DB + 1)) ? tidx : tidx + TW'(1);
      end
      if (rx_stop) rd_on <= 1'b0;
    end
  end

  assert_pec_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_first && rx_data[4] |-> !rx_ack);

  assert_orphan_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_first && !rx_data[7] && !seq_open |-> !rx_ack);

  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && ((rx_valid && rx_first) || (tx_req && tx_first)) |-> !rx_ack && !tx_ack);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_cfg)
                                && $stable(bus_addr) && $stable(bus_wdata));

  assert_issue_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(rx_stop));

  assert_idle_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ack |-> tx_data == 8'h00);
endmodule

// File: tb/smb_cmd_seq_tb.sv
module smb_cmd_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_first = 0, rx_stop = 0, tx_req = 0, tx_first = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ack, tx_ack, bus_valid, bus_write, bus_cfg;
  logic [7:0]  tx_data;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready = 0;
  logic [31:0] bus_rdata = 0;

  smb_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
    .rx_stop(rx_stop), .rx_ack(rx_ack), .tx_req(tx_req), .tx_first(tx_first), .tx_ack(tx_ack),
    .tx_data(tx_data), .bus_valid(bus_valid), .bus_write(bus_write), .bus_cfg(bus_cfg),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata));

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit         m_in, m_seq, m_bv, m_bw, m_bcfg, m_rd, m_avail;
  logic [7:0] m_cmd;
  logic [7:0] m_q[$];
  logic [15:0] m_baddr;
  logic [31:0] m_bwd, m_rdata;
  int         m_t;

  function automatic bit m_busy(); return m_in || m_bv; endfunction
  function automatic int m_need(); return m_cmd[0] ? 2 : 6; endfunction
  function automatic bit e_rx_ack();
    if (!rx_valid) return 0;
    if (rx_first) return !m_busy() && !rx_data[4] && (rx_data[7] || m_seq);
    return m_in && (m_q.size() < m_need());
  endfunction
  function automatic bit e_tx_ack();
    if (!tx_req) return 0;
    return tx_first ? !m_busy() : m_rd;
  endfunction
  function automatic logic [7:0] e_tx_data();
    int i;
    if (!e_tx_ack()) return 8'h00;
    i = tx_first ? 0 : m_t;
    if (i == 0) return {7'b0, m_avail};
    if (i <= 4) return m_rdata[31 - 8 * (i - 1) -: 8];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_seq = 0; m_bv = 0; m_bw = 0; m_bcfg = 0; m_rd = 0; m_avail = 0;
      m_cmd = 0; m_q.delete(); m_t = 0;
    end else begin
      bit ra, ta;
      int ti;
      ra = e_rx_ack(); ta = e_tx_ack(); ti = tx_first ? 0 : m_t;
      if (rx_valid && rx_first && ra) begin
        m_in = 1; m_cmd = rx_data; m_q.delete(); m_seq = !rx_data[6];
        if (rx_data[0]) m_avail = 0;
      end else if (ra) m_q.push_back(rx_data);
      if (m_bv && bus_ready) begin
        m_bv = 0;
        if (!m_bw) begin m_rdata = bus_rdata; m_avail = 1; end
      end
      if (rx_stop && m_in) begin
        m_in = 0;
        if (m_q.size() == m_need()) begin
          m_bv = 1; m_bw = !m_cmd[0]; m_bcfg = m_cmd[5];
          m_baddr = {m_q[0], m_q[1]};
          if (m_bw) m_bwd = {m_q[2], m_q[3], m_q[4], m_q[5]};
        end
      end
      if (ta) begin m_rd = 1; m_t = (ti >= 5) ? 5 : ti + 1; end
      if (rx_stop) m_rd = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) chk("R2", "rx_ack vs model", rx_ack, e_rx_ack());
      if (tx_req) begin
        chk("R8", "tx_ack vs model", tx_ack, e_tx_ack());
        chk("R9", "tx_data vs model", tx_data, e_tx_data());
      end
      chk("R10", "bus_valid vs model", bus_valid, m_bv);
      if (m_bv) begin
        chk("R7", "bus_write vs model", bus_write, m_bw);
        chk("R4", "bus_cfg vs model", bus_cfg, m_bcfg);
        chk("R5", "bus_addr vs model", bus_addr, m_baddr);
        if (m_bw) chk("R5", "bus_wdata vs model", bus_wdata, m_bwd);
      end
    end
  end

  // internal bus responder with a fixed delay
  int          lat = 0, wr_count = 0;
  logic [15:0] log_addr;
  logic [31:0] log_data;
  logic        log_cfg;
  always @(posedge clk) begin
    #1;
    if (bus_ready) begin bus_ready = 0; lat = 0; end
    else if (bus_valid) begin
      lat++;
      if (lat == 3) begin
        bus_ready = 1;
        bus_rdata = {~bus_addr, bus_addr};
        if (bus_write) begin
          wr_count++; log_addr = bus_addr; log_data = bus_wdata; log_cfg = bus_cfg;
        end
      end
    end
  end

  bit         acks[$];
  logic [7:0] got[$];

  task automatic step();
    @(posedge clk); #1;
    rx_valid = 0; rx_first = 0; rx_stop = 0; tx_req = 0; tx_first = 0;
  endtask

  task automatic wr_txn(input logic [7:0] b[$]);
    acks.delete();
    foreach (b[i]) begin
      step(); rx_valid = 1; rx_first = (i == 0); rx_data = b[i];
      @(negedge clk); acks.push_back(rx_ack);
      step();
    end
    rx_stop = 1; step();
  endtask

  task automatic rd_txn(input int n);
    acks.delete(); got.delete();
    for (int i = 0; i < n; i++) begin
      step(); tx_req = 1; tx_first = (i == 0);
      @(negedge clk); acks.push_back(tx_ack); got.push_back(tx_data);
      step();
    end
    rx_stop = 1; step();
  endtask

  task automatic settle(); repeat (10) step(); endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "bus_valid after reset", bus_valid, 0);
    chk("R1", "rx_ack after reset", rx_ack, 0);
    chk("R1", "tx_ack after reset", tx_ack, 0);

    rd_txn(2);
    chk("R9", "read ack before data", acks[0], 1);
    chk("R9", "status before any read", got[0], 8'h00);

    wr_txn('{8'hE0, 8'h12, 8'h34, 8'hDE, 8'hAD, 8'hBE, 8'hEF}); settle();
    chk("R5", "cfg write count", wr_count, 1);
    chk("R5", "cfg write addr", log_addr, 16'h1234);
    chk("R5", "cfg write data", log_data, 32'hDEADBEEF);
    chk("R4", "cfg space flag", log_cfg, 1);

    wr_txn('{8'hC0, 8'hAB, 8'hCD, 8'h01, 8'h02, 8'h03, 8'h04}); settle();
    chk("R4", "mem space flag", log_cfg, 0);
    chk("R5", "mem offset", log_addr, 16'hABCD);

    w = wr_count;
    wr_txn('{8'hD0, 8'h00, 8'h04, 8'h01, 8'h02, 8'h03, 8'h04}); settle();
    chk("R3", "checksum cmd rejected", acks[0], 0);
    chk("R3", "no write after reject", wr_count, w);

    wr_txn('{8'h20, 8'h00, 8'h08, 8'h01, 8'h02, 8'h03, 8'h04}); settle();
    chk("R2", "continuation without open sequence", acks[0], 0);
    chk("R1", "no write from orphan", wr_count, w);

    wr_txn('{8'h80, 8'h00, 8'h10, 8'h11, 8'h22, 8'h33, 8'h44}); settle();
    chk("R2", "begin accepted", acks[0], 1);
    wr_txn('{8'h40, 8'h00, 8'h14, 8'h55, 8'h66, 8'h77, 8'h88}); settle();
    chk("R2", "continuation accepted", acks[0], 1);
    chk("R2", "continuation data", log_data, 32'h55667788);
    wr_txn('{8'h40, 8'h00, 8'h18, 8'h01, 8'h02, 8'h03, 8'h04}); settle();
    chk("R2", "sequence closed by end bit", acks[0], 0);

    w = wr_count;
    wr_txn('{8'hC0, 8'h00, 8'h20, 8'h99}); settle();
    chk("R6", "partial write bytes accepted", acks[3], 1);
    chk("R6", "partial write discarded", wr_count, w);
    wr_txn('{8'hC0, 8'h00, 8'h24, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}); settle();
    chk("R6", "seventh data byte rejected", acks[7], 0);
    chk("R6", "full write issued", log_data, 32'h01020304);

    wr_txn('{8'hE0, 8'h00, 8'h28, 8'hA1, 8'hA2, 8'hA3, 8'hA4});
    wr_txn('{8'hE0, 8'h00, 8'h2C, 8'h01, 8'h02, 8'h03, 8'h04}); settle();
    chk("R8", "command during access rejected", acks[0], 0);
    chk("R8", "first access intact", log_addr, 16'h0028);
    wr_txn('{8'hE0, 8'h00, 8'h30, 8'hB1, 8'hB2, 8'hB3, 8'hB4});
    rd_txn(1); settle();
    chk("R8", "read start during access rejected", acks[0], 0);

    wr_txn('{8'hE1, 8'h00, 8'h40, 8'h77}); settle();
    chk("R7", "byte after read address rejected", acks[3], 0);
    rd_txn(6);
    chk("R9", "status after read", got[0], 8'h01);
    chk("R9", "read byte [31:24]", got[1], 8'hFF);
    chk("R9", "read byte [23:16]", got[2], 8'hBF);
    chk("R9", "read byte [15:8]", got[3], 8'h00);
    chk("R9", "read byte [7:0]", got[4], 8'h40);
    chk("R9", "filler byte", got[5], 8'hFF);

    wr_txn('{8'hC1, 8'h12, 8'h00});
    rd_txn(1); settle();
    chk("R8", "read start while read pending", acks[0], 0);
    rd_txn(3);
    chk("R7", "mem read data", {got[1], got[2]}, 16'hEDFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule